// File: doc/BRIEF.md
# Tagged Statistical Packet Multiplexer

This block merges packets from several input channels onto one shared word-wide link, then splits them back out again at the far end of that link. Each input channel delivers packet words over a ready/valid handshake, with a flag on the final word. An input buffer on each channel holds the words until the whole packet has arrived. A round-robin arbiter then chooses among the channels that hold a complete packet. The chosen packet goes out as one header word that carries the channel number, followed by its payload words without a break.

On the receiving side, a demultiplexer reads the header word to learn the destination. It then writes the payload into the buffer for that output. Each output drains through its own ready/valid handshake, at whatever rate its consumer accepts. Channel i always comes out on output i, so the block only multiplexes and never switches between arbitrary ports. When the destination buffer is full, the link stalls. No word is ever discarded.

The link is brought out on observation ports so that the header and the framing can be inspected.

Top module: `tagStatMux`

## Requirements
- R1: Each input channel accepts a word on a clock edge where its valid and ready are both high. Ready is high exactly when the input buffer of that channel holds fewer than IN_DEPTH words.
- R2: On the link, every packet begins with one header word whose value equals the input channel number. The upper bits of the header word are zero, and its last flag is low.
- R3: A header for channel c appears only after the last word of that packet has been accepted on input c. The payload that follows consists of that packet's words in order, with no word of another packet in between.
- R4: The arbiter grants the waiting channels in round-robin order. After channel c is served, the next grant goes to the first waiting channel in the order c+1, c+2, and so on, modulo NUM_CH. After reset the search starts at channel 0.
- R5: The demultiplexer delivers each payload word on the output whose index equals the header value. The header word itself is never delivered. The output last flag is high on the final word of each packet.
- R6: Per channel, the words leave the output in the same order and with the same values as they entered the input, and none is lost.
- R7: While a link word is valid and the link ready is low (because the destination buffer is full), the link word, its last flag and its valid stay unchanged in the next cycle.
- R8: During reset, and in the first cycle after it, all outputs and the link are not valid, and all input readies are high.
- R9: While an output is valid and its ready is low, that output stays valid in the next cycle with unchanged data and last flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | NUM_CH | Word valid, one bit per input channel |
| inData | input | NUM_CH x DATA_W | Input word per channel |
| inLast | input | NUM_CH | Final word of a packet, per channel |
| inReady | output | NUM_CH | Input buffer has space, per channel |
| outValid | output | NUM_CH | Output word valid, per output |
| outData | output | NUM_CH x DATA_W | Output word per output |
| outLast | output | NUM_CH | Final word of a packet, per output |
| outReady | input | NUM_CH | Consumer accepts the output word |
| linkValid | output | 1 | Link carries a word (observation) |
| linkData | output | DATA_W | Link word, a header or a payload word (observation) |
| linkLast | output | 1 | Link word ends a packet (observation) |
| linkReady | output | 1 | Demultiplexer accepts the link word (observation) |

## Verification
Each fault class shows up at the ports after a predictable delay:
- A wrong count of complete packets in an input buffer shows up on the link at once. A header appears before that packet's last word was accepted, or a channel holding a finished packet is skipped in the round-robin order.
- A wrong destination register or a broken framing state in the demultiplexer shows up one cycle after the affected payload word crosses the link. The word appears on the wrong output, or a header value leaks out as data.
- A pointer or occupancy error in any buffer shows up as a wrong ready level in the same cycle. It shows up as a data or order mismatch at the first word popped after the error.

// File: rtl/tagMuxPkg.sv
package tagMuxPkg;

  typedef enum logic [1:0] {
    MX_IDLE,
    MX_HDR,
    MX_PAY
  } muxStateT;

  typedef enum logic {
    DX_HDR,
    DX_PAY
  } demuxStateT;

  // strobes from the mux control to the mux datapath
  typedef struct packed {
    logic hdrPhase;  // link carries the channel header word
    logic popEn;     // remove the head word of the selected input buffer
  } muxStrobeT;

endpackage

// File: rtl/wordFifo.sv
module wordFifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             empty,
  output logic             full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign popData = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  // R1: a writer never pushes into a full buffer
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(push && full));

  // R6: a reader never pops an empty buffer
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(pop && empty));

  // R9: an unread head word stays put
  p_head_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!empty && !pop) |=> (!empty && $stable(popData)));

endmodule

// File: rtl/muxDatapath.sv
module muxDatapath
  import tagMuxPkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int DATA_W   = 8,
  parameter int IN_DEPTH = 8,
  parameter int CH_W     = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CH-1:0]              inValid,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  inData,
  input  logic [NUM_CH-1:0]              inLast,
  output logic [NUM_CH-1:0]              inReady,
  input  muxStrobeT                      strobe,
  input  logic [CH_W-1:0]                sel,
  output logic [NUM_CH-1:0]              pktAvail,
  output logic                           headLast,
  output logic [DATA_W-1:0]              linkData
);

  localparam int PC_W = $clog2(IN_DEPTH + 1);

  logic [DATA_W:0] headWord [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : gIn
    logic            push;
    logic            pop;
    logic            bufFull;
    logic            bufEmpty;
    logic [PC_W-1:0] pktCnt;

    assign push       = inValid[g] && inReady[g];
    assign pop        = strobe.popEn && (sel == CH_W'(g));
    assign inReady[g] = !bufFull;
    assign pktAvail[g] = (pktCnt != '0);

    wordFifo #(.WIDTH(DATA_W + 1), .DEPTH(IN_DEPTH)) u_inBuf (
      .clk      (clk),
      .rstN     (rstN),
      .push     (push),
      .pushData ({inLast[g], inData[g]}),
      .pop      (pop),
      .popData  (headWord[g]),
      .empty    (bufEmpty),
      .full     (bufFull)
    );

    // complete packets currently held in this buffer
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pktCnt <= '0;
      else pktCnt <= pktCnt + PC_W'(push && inLast[g]) - PC_W'(pop && headWord[g][DATA_W]);
    end

    // R3: a held complete packet implies stored words
    p_cnt_words_r3: assert property (@(posedge clk) disable iff (!rstN)
      pktAvail[g] |-> !bufEmpty);
  end

  assign headLast = headWord[sel][DATA_W];

  always_comb begin
    linkData = '0;
    if (strobe.hdrPhase) linkData[CH_W-1:0] = sel;
    else                 linkData = headWord[sel][DATA_W-1:0];
  end

  // R3: payload is only read from a channel that holds a finished packet
  p_pop_complete_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popEn |-> pktAvail[sel]);

endmodule

// File: rtl/muxControl.sv
module muxControl
  import tagMuxPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pktAvail,
  input  logic              headLast,
  input  logic              linkReady,
  output muxStrobeT         strobe,
  output logic [CH_W-1:0]   sel,
  output logic              linkValid,
  output logic              linkLast
);

  muxStateT        state;
  logic [CH_W-1:0] rrLast;
  logic [CH_W-1:0] pick;
  logic            found;

  // round-robin search starting just after the last served channel
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM_CH; k++) begin
      if (!found && pktAvail[(int'(rrLast) + k) % NUM_CH]) begin
        found = 1'b1;
        pick  = CH_W'((int'(rrLast) + k) % NUM_CH);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= MX_IDLE;
      sel    <= '0;
      rrLast <= CH_W'(NUM_CH - 1);
    end else begin
      unique case (state)
        MX_IDLE: if (found) begin
          sel    <= pick;
          rrLast <= pick;
          state  <= MX_HDR;
        end
        MX_HDR:  if (linkReady) state <= MX_PAY;
        MX_PAY:  if (linkReady && headLast) state <= MX_IDLE;
        default: state <= MX_IDLE;
      endcase
    end
  end

  assign linkValid       = (state != MX_IDLE);
  assign linkLast        = (state == MX_PAY) && headLast;
  assign strobe.hdrPhase = (state == MX_HDR);
  assign strobe.popEn    = (state == MX_PAY) && linkReady;

  // R3: the selected channel is frozen for the whole packet
  p_sel_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && !(linkReady && linkLast)) |=> (linkValid && $stable(sel)));

endmodule

// File: rtl/tagDemux.sv
module tagDemux
  import tagMuxPkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int DATA_W    = 8,
  parameter int OUT_DEPTH = 4,
  parameter int CH_W      = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          linkValid,
  input  logic [DATA_W-1:0]             linkData,
  input  logic                          linkLast,
  output logic                          linkReady,
  output logic [NUM_CH-1:0]             outValid,
  output logic [NUM_CH-1:0][DATA_W-1:0] outData,
  output logic [NUM_CH-1:0]             outLast,
  input  logic [NUM_CH-1:0]             outReady
);

  demuxStateT      state;
  logic [CH_W-1:0] dest;
  logic [NUM_CH-1:0] outFull;
  logic            payXfer;

  assign linkReady = (state == DX_HDR) ? 1'b1 : !outFull[dest];
  assign payXfer   = (state == DX_PAY) && linkValid && linkReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= DX_HDR;
      dest  <= '0;
    end else begin
      unique case (state)
        DX_HDR: if (linkValid) begin
          dest  <= linkData[CH_W-1:0];
          state <= DX_PAY;
        end
        DX_PAY: if (payXfer && linkLast) state <= DX_HDR;
        default: state <= DX_HDR;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gOut
    logic bufEmpty;

    assign outValid[g] = !bufEmpty;

    wordFifo #(.WIDTH(DATA_W + 1), .DEPTH(OUT_DEPTH)) u_outBuf (
      .clk      (clk),
      .rstN     (rstN),
      .push     (payXfer && (dest == CH_W'(g))),
      .pushData ({linkLast, linkData}),
      .pop      (outValid[g] && outReady[g]),
      .popData  ({outLast[g], outData[g]}),
      .empty    (bufEmpty),
      .full     (outFull[g])
    );
  end

  // R2: every header word names an existing channel and does not end a packet
  p_hdr_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && state == DX_HDR) |-> (int'(linkData) < NUM_CH && !linkLast));

  // R7: a stalled link word is held by the sender
  p_link_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && !linkReady) |=> (linkValid && $stable(linkData) && $stable(linkLast)));

endmodule

// File: rtl/tagStatMux.sv
module tagStatMux
  import tagMuxPkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int DATA_W    = 8,
  parameter int IN_DEPTH  = 8,
  parameter int OUT_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0]             inValid,
  input  logic [NUM_CH-1:0][DATA_W-1:0] inData,
  input  logic [NUM_CH-1:0]             inLast,
  output logic [NUM_CH-1:0]             inReady,
  output logic [NUM_CH-1:0]             outValid,
  output logic [NUM_CH-1:0][DATA_W-1:0] outData,
  output logic [NUM_CH-1:0]             outLast,
  input  logic [NUM_CH-1:0]             outReady,
  output logic                          linkValid,
  output logic [DATA_W-1:0]             linkData,
  output logic                          linkLast,
  output logic                          linkReady
);

  localparam int CH_W = $clog2(NUM_CH);

  muxStrobeT         strobe;
  logic [CH_W-1:0]   sel;
  logic [NUM_CH-1:0] pktAvail;
  logic              headLast;

  muxDatapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .IN_DEPTH(IN_DEPTH), .CH_W(CH_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inData   (inData),
    .inLast   (inLast),
    .inReady  (inReady),
    .strobe   (strobe),
    .sel      (sel),
    .pktAvail (pktAvail),
    .headLast (headLast),
    .linkData (linkData)
  );

  muxControl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .pktAvail  (pktAvail),
    .headLast  (headLast),
    .linkReady (linkReady),
    .strobe    (strobe),
    .sel       (sel),
    .linkValid (linkValid),
    .linkLast  (linkLast)
  );

  tagDemux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .OUT_DEPTH(OUT_DEPTH), .CH_W(CH_W)) u_dx (
    .clk       (clk),
    .rstN      (rstN),
    .linkValid (linkValid),
    .linkData  (linkData),
    .linkLast  (linkLast),
    .linkReady (linkReady),
    .outValid  (outValid),
    .outData   (outData),
    .outLast   (outLast),
    .outReady  (outReady)
  );

endmodule

// File: tb/tagStatMux_tb.sv
module tagStatMux_tb;

  localparam int NUM_CH    = 4;
  localparam int DATA_W    = 8;
  localparam int IN_DEPTH  = 8;
  localparam int OUT_DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_CH-1:0]             inValid = '0;
  logic [NUM_CH-1:0][DATA_W-1:0] inData = '0;
  logic [NUM_CH-1:0]             inLast = '0;
  logic [NUM_CH-1:0]             inReady;
  logic [NUM_CH-1:0]             outValid;
  logic [NUM_CH-1:0][DATA_W-1:0] outData;
  logic [NUM_CH-1:0]             outLast;
  logic [NUM_CH-1:0]             outReady = '0;
  logic                          linkValid;
  logic [DATA_W-1:0]             linkData;
  logic                          linkLast;
  logic                          linkReady;

  always #5 clk = ~clk;

  tagStatMux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) u_dut (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inData(inData), .inLast(inLast), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outLast(outLast), .outReady(outReady),
    .linkValid(linkValid), .linkData(linkData), .linkLast(linkLast), .linkReady(linkReady)
  );

  int checks = 0;
  int failures = 0;

  // model state
  logic [DATA_W:0] expQ  [NUM_CH][$];
  logic [DATA_W:0] linkQ [NUM_CH][$];
  int remLen  [NUM_CH];
  int inFill  [NUM_CH];
  int doneCnt [NUM_CH];
  int sentCnt [NUM_CH];
  int hdrLog  [64];
  int hdrCnt = 0;
  int curCh = 0;
  bit expectHdr = 1'b1;
  bit allowNew = 1'b0;
  bit forceValid = 1'b0;
  bit randOut = 1'b0;
  int budget = 0;
  logic [NUM_CH-1:0] readyMask = '1;
  bit stallSeen = 1'b0;
  bit fullSeen = 1'b0;
  bit prevLinkStall = 1'b0;
  logic [DATA_W-1:0] prevLinkData;
  logic prevLinkLast;
  bit prevOutStall [NUM_CH];
  logic [DATA_W-1:0] prevOutData [NUM_CH];
  logic prevOutLast [NUM_CH];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit expInReady(input int fill);
    return fill < IN_DEPTH;
  endfunction

  task automatic drive();
    for (int c = 0; c < NUM_CH; c++) begin
      if (remLen[c] == 0 && allowNew && budget > 0 && ($urandom % 6) == 0) begin
        remLen[c] = 1 + ($urandom % IN_DEPTH);
        budget--;
      end
      inValid[c]  = (remLen[c] > 0) && (forceValid || ($urandom % 4) != 0);
      inData[c]   = DATA_W'($urandom);
      inLast[c]   = (remLen[c] == 1);
      outReady[c] = readyMask[c] && (!randOut || ($urandom % 2) == 1);
    end
  endtask

  task automatic observe();
    logic [DATA_W:0] w;
    int hc;
    // R1: ready follows the occupancy of the input buffer
    for (int c = 0; c < NUM_CH; c++) begin
      chk(inReady[c] == expInReady(inFill[c]), "R1", "inReady", inReady[c], expInReady(inFill[c]));
      if (!inReady[c]) fullSeen = 1'b1;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (inValid[c] && inReady[c]) begin
        expQ[c].push_back({inLast[c], inData[c]});
        linkQ[c].push_back({inLast[c], inData[c]});
        inFill[c]++;
        remLen[c]--;
        if (inLast[c]) doneCnt[c]++;
      end
    end
    // link monitor
    if (prevLinkStall)
      chk(linkValid && linkData == prevLinkData && linkLast == prevLinkLast,
          "R7", "stalled link word changed", {linkValid, linkLast, linkData}, {1'b1, prevLinkLast, prevLinkData});
    prevLinkStall = linkValid && !linkReady;
    prevLinkData  = linkData;
    prevLinkLast  = linkLast;
    if (linkValid && !linkReady) stallSeen = 1'b1;
    if (linkValid && linkReady) begin
      if (expectHdr) begin
        hc = int'(linkData);
        chk(hc < NUM_CH && !linkLast, "R2", "header word", {linkLast, linkData}, 0);
        if (hc < NUM_CH) begin
          chk(doneCnt[hc] > sentCnt[hc], "R3", "header before packet complete", doneCnt[hc], sentCnt[hc] + 1);
          sentCnt[hc]++;
          curCh = hc;
          if (hdrCnt < 64) hdrLog[hdrCnt] = hc;
          hdrCnt++;
        end
        expectHdr = 1'b0;
      end else begin
        if (linkQ[curCh].size() == 0) begin
          chk(1'b0, "R3", "link word with nothing pending", {linkLast, linkData}, 0);
        end else begin
          w = linkQ[curCh].pop_front();
          chk({linkLast, linkData} == w, "R3", "link payload", {linkLast, linkData}, w);
          inFill[curCh]--;
        end
        if (linkLast) expectHdr = 1'b1;
      end
    end
    // outputs
    for (int i = 0; i < NUM_CH; i++) begin
      if (prevOutStall[i])
        chk(outValid[i] && outData[i] == prevOutData[i] && outLast[i] == prevOutLast[i],
            "R9", "stalled output changed", {outValid[i], outLast[i], outData[i]},
            {1'b1, prevOutLast[i], prevOutData[i]});
      prevOutStall[i] = outValid[i] && !outReady[i];
      prevOutData[i]  = outData[i];
      prevOutLast[i]  = outLast[i];
      if (outValid[i] && outReady[i]) begin
        if (expQ[i].size() == 0) begin
          chk(1'b0, "R5", "word on output with nothing expected", {outLast[i], outData[i]}, 0);
        end else begin
          w = expQ[i].pop_front();
          chk({outLast[i], outData[i]} == w, "R5 R6", "output word", {outLast[i], outData[i]}, w);
        end
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    drive();
    #1;
    observe();
  endtask

  task automatic waitIdle();
    bit idle;
    for (int n = 0; n < 3000; n++) begin
      step();
      idle = !linkValid;
      for (int c = 0; c < NUM_CH; c++)
        if (remLen[c] != 0 || expQ[c].size() != 0) idle = 1'b0;
      if (idle) break;
    end
    for (int n = 0; n < 5; n++) step();
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int rrExp [8];
    void'($urandom(32'h5eed));
    for (int c = 0; c < NUM_CH; c++) begin
      remLen[c] = 0; inFill[c] = 0; doneCnt[c] = 0; sentCnt[c] = 0;
      prevOutStall[c] = 1'b0;
    end
    // R8: state during reset
    repeat (4) @(negedge clk);
    chk(outValid == '0 && !linkValid, "R8", "valid during reset", {outValid, linkValid}, 0);
    chk(inReady == '1, "R8", "inReady during reset", inReady, {NUM_CH{1'b1}});
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(outValid == '0 && !linkValid && inReady == '1, "R8", "first cycle after reset",
        {outValid, linkValid, inReady}, {NUM_CH{1'b1}});

    // R4: round-robin order, directed
    readyMask = '1; randOut = 1'b0; forceValid = 1'b1; allowNew = 1'b0;
    for (int c = 0; c < NUM_CH; c++) remLen[c] = 1;
    waitIdle();
    remLen[1] = 1; remLen[2] = 1;
    waitIdle();
    remLen[0] = 1; remLen[3] = 1;
    waitIdle();
    rrExp = '{0, 1, 2, 3, 1, 2, 3, 0};
    chk(hdrCnt == 8, "R4", "header count", hdrCnt, 8);
    for (int k = 0; k < 8; k++)
      chk(hdrLog[k] == rrExp[k], "R4", "grant order", hdrLog[k], rrExp[k]);

    // R7 and R1: stalled output 1 back-pressures the link and fills input 1
    readyMask = 4'b1101;
    for (int n = 0; n < 80; n++) begin
      if (remLen[1] == 0) remLen[1] = IN_DEPTH;
      step();
    end
    chk(stallSeen, "R7", "link stall observed", stallSeen, 1);
    chk(fullSeen, "R1", "input full observed", fullSeen, 1);
    readyMask = '1;
    waitIdle();

    // random traffic with random output rates
    forceValid = 1'b0; randOut = 1'b1; allowNew = 1'b1; budget = 150;
    for (int n = 0; n < 3000; n++) step();
    allowNew = 1'b0; randOut = 1'b0;
    waitIdle();

    // R6: nothing lost
    for (int c = 0; c < NUM_CH; c++) begin
      chk(expQ[c].size() == 0, "R6", "words never delivered", expQ[c].size(), 0);
      chk(sentCnt[c] == doneCnt[c], "R6", "packets not sent", sentCnt[c], doneCnt[c]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule